// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This block is a passive monitor that sits beside an SDRAM controller and watches the command pins on every rising clock edge. It decodes each command. It keeps an open or closed flag and a set of elapsed-cycle timers for every bank, and it follows any burst that closes its own row when it ends. When a command breaks a state rule or a minimum spacing, the block raises a one-cycle error pulse and a numeric error code, and it sets a flag that stays high until reset.

All timing minimums are parameters counted in clock cycles. The monitor also shows which banks are open. For data masking it gives two outputs: the write mask that applies in the current cycle, and a predicted high-impedance strobe for read data that follows the mask input two edges late. The block drives nothing onto the memory bus.

Top module: `sdr_bank_checker`

## Requirements
- R1: A command counts only when chip select is low at the sampling edge and clock enable was high at the previous edge. The pins {ras_n,cas_n,we_n} encode the command: 3'b011 activate, 3'b101 read, 3'b100 write, 3'b010 precharge, 3'b001 refresh, 3'b000 mode set, 3'b110 burst stop, 3'b111 no-operation. A command that does not count has no effect on any output.
- R2: Each check runs on the command sampled at edge n. The result shows after edge n: err_pulse is high for that one cycle, err_code takes the new code and keeps it until the next error, and err_sticky stays high until reset. When several rules break together, the lowest code is reported. The codes are 1 mode-set spacing, 2 bank not idle, 3 auto-precharge busy, 4 bank idle, 5 bank already open, 6 activate-to-column, 7 active time, 8 precharge time, 9 row cycle, 10 activate-to-activate. After reset all outputs are 0.
- R3: Any command other than no-operation that comes fewer than T_MRD cycles after a mode set gives code 1.
- R4: A mode set or refresh while any bank is open gives code 2.
- R5: A read or write to a bank opened with A10 high runs a burst with auto-precharge that lasts BURST_LEN cycles, counting the command cycle. While that burst runs, any read or write gives code 3 and is ignored. The bank closes at the last cycle of the burst.
- R6: A read or write to a closed bank gives code 4 and is ignored. An activate to an open bank gives code 5 and is ignored.
- R7: A read or write fewer than T_RCD cycles after the activate of its bank gives code 6.
- R8: A precharge with A10 high targets all banks, and with A10 low it targets bank ba. Each targeted open bank closes. A targeted bank that opened fewer than T_RAS cycles earlier gives code 7. A precharge to an idle bank is legal.
- R9: An activate fewer than T_RP cycles after its bank closed gives code 8. The bank may have closed by a precharge or at the end of an auto-precharge burst.
- R10: An activate fewer than T_RC cycles after the previous activate of the same bank gives code 9. An activate fewer than T_RRD cycles after an activate to any bank gives code 10.
- R11: Reads and writes to an open bank on consecutive cycles are legal and raise no error.
- R12: wr_mask equals dqm, with no register, during each cycle of a write data window. That window starts at an accepted write, lasts BURST_LEN cycles and ends early at an accepted read. rd_hiz_pred after edge n equals dqm as sampled at edge n-1.
- R13: bank_open[b] is high exactly while bank b is open, and updates after the edge of the command that opens or closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-precharge select |
| dqm | input | 1 | Data mask pin |
| err_pulse | output | 1 | One-cycle error strobe |
| err_code | output | 4 | Code of the most recent error |
| err_sticky | output | 1 | Set by any error, cleared by reset |
| bank_open | output | 2**BA_W | Open flag per bank |
| wr_mask | output | 1 | Write data masked in this cycle |
| rd_hiz_pred | output | 1 | Predicted read output high-impedance strobe |

## Verification
The hardest case to reach is an activate on the edge right after an auto-precharge burst ends. The bank closed without any precharge on the pins, and it must be rejected for the precharge time alone, not for being open. The stimulus reaches this case in three steps. It opens a bank, waits out the activate-to-column time, and issues a read with A10 high. It then tries a second column command inside the burst to trigger the busy error. Finally it issues the activate one cycle after the burst's last beat, and once more after T_RP cycles. A second sequence makes the precharge-time rule and the row-cycle rule fail on the same edge, to show that the lower code wins.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

   // {ras_n, cas_n, we_n} command encoding
   typedef enum logic [2:0] {
      CMD_MRS = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_BST = 3'b110,
      CMD_NOP = 3'b111
   } cmd_e;

   // lower value wins when several rules break on one edge
   typedef enum logic [3:0] {
      ERR_NONE      = 4'd0,
      ERR_MRD       = 4'd1,
      ERR_NOT_IDLE  = 4'd2,
      ERR_AP_BUSY   = 4'd3,
      ERR_BANK_IDLE = 4'd4,
      ERR_BANK_OPEN = 4'd5,
      ERR_RCD       = 4'd6,
      ERR_RAS       = 4'd7,
      ERR_RP        = 4'd8,
      ERR_RC        = 4'd9,
      ERR_RRD       = 4'd10
   } err_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
   import sdr_chk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   logic cke_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cke_q <= 1'b0;
      else        cke_q <= cke;
   end

   // suspended clock or deselect reads as no-operation
   always_comb begin
      if (cke_q && !cs_n) cmd = cmd_e'({ras_n, cas_n, we_n});
      else                cmd = CMD_NOP;
   end

endmodule

// File: rtl/sdr_gap_ctr.sv
module sdr_gap_ctr #(
   parameter int W   = 4,
   parameter int MAX = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] gap
);

   localparam logic [W-1:0] LIM = W'(MAX);

   // cycles since the last restart, saturating; reset reads as "long ago"
   always_ff @(posedge clk) begin
      if (!rst_n)       gap <= LIM;
      else if (restart) gap <= W'(1);
      else if (gap < LIM) gap <= gap + W'(1);
   end

endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
   parameter int CNT_W   = 4,
   parameter int CNT_MAX = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_req,
   input  logic             close_req,
   output logic             is_open,
   output logic [CNT_W-1:0] act_gap,
   output logic [CNT_W-1:0] pre_gap
);

   logic close_live;

   assign close_live = close_req && is_open;

   always_ff @(posedge clk) begin
      if (!rst_n)         is_open <= 1'b0;
      else if (open_req)  is_open <= 1'b1;
      else if (close_req) is_open <= 1'b0;
   end

   sdr_gap_ctr #(.W(CNT_W), .MAX(CNT_MAX)) u_act_gap (
      .clk(clk), .rst_n(rst_n), .restart(open_req), .gap(act_gap)
   );

   sdr_gap_ctr #(.W(CNT_W), .MAX(CNT_MAX)) u_pre_gap (
      .clk(clk), .rst_n(rst_n), .restart(close_live), .gap(pre_gap)
   );

   AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      open_req |=> is_open && act_gap == CNT_W'(1)); // R13

endmodule

// File: rtl/sdr_dqm_track.sv
module sdr_dqm_track #(
   parameter int BURST_LEN = 4,
   parameter int BL_W      = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dqm,
   input  logic wr_start,
   input  logic rd_start,
   output logic wr_mask,
   output logic rd_hiz
);

   logic dqm_d1;
   logic dqm_d2;

   // read mask takes effect two edges after sampling
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dqm_d1 <= 1'b0;
         dqm_d2 <= 1'b0;
      end else begin
         dqm_d1 <= dqm;
         dqm_d2 <= dqm_d1;
      end
   end

   assign rd_hiz = dqm_d2;

   // write mask applies in the very cycle it is sampled
   if (BURST_LEN == 1) begin : g_wr_single
      assign wr_mask = dqm && wr_start;
   end else begin : g_wr_burst
      localparam logic [BL_W-1:0] BL_M1 = BL_W'(BURST_LEN - 1);
      logic [BL_W-1:0] wr_left;

      always_ff @(posedge clk) begin
         if (!rst_n)              wr_left <= '0;
         else if (wr_start)       wr_left <= BL_M1;
         else if (rd_start)       wr_left <= '0;
         else if (wr_left != '0)  wr_left <= wr_left - BL_W'(1);
      end

      assign wr_mask = dqm && (wr_start || wr_left != '0);

      AST_WR_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         rd_start |=> wr_left == '0); // R12
   end

endmodule

// File: rtl/sdr_bank_checker.sv
module sdr_bank_checker
   import sdr_chk_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_RC      = 10,
   parameter int T_RRD     = 2,
   parameter int T_MRD     = 2,
   parameter int BURST_LEN = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic                 a10,
   input  logic                 dqm,
   output logic                 err_pulse,
   output logic [3:0]           err_code,
   output logic                 err_sticky,
   output logic [(1<<BA_W)-1:0] bank_open,
   output logic                 wr_mask,
   output logic                 rd_hiz_pred
);

   localparam int NBANK   = 1 << BA_W;
   localparam int M1      = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int M2      = (T_RAS > T_RC) ? T_RAS : T_RC;
   localparam int M3      = (T_RRD > T_MRD) ? T_RRD : T_MRD;
   localparam int M12     = (M1 > M2) ? M1 : M2;
   localparam int CNT_MAX = (M12 > M3) ? M12 : M3;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int BL_W    = $clog2(BURST_LEN) + 1;

   localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD);
   localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS);
   localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC);
   localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD);
   localparam logic [CNT_W-1:0] L_MRD = CNT_W'(T_MRD);

   initial begin
      assert (BA_W >= 1 && BA_W <= 3) else $error("BA_W out of range");
      assert (BURST_LEN >= 1) else $error("BURST_LEN must be positive");
      assert (T_RCD >= 1 && T_RP >= 1 && T_RAS >= 1) else $error("timing minimum below 1");
      assert (T_RRD >= 1 && T_MRD >= 1) else $error("timing minimum below 1");
      assert (T_RC >= T_RAS) else $error("T_RC shorter than T_RAS");
   end

   // ---------------- command decode ----------------
   cmd_e cmd;

   sdr_cmd_decode u_dec (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   logic is_act, is_rd, is_wr, is_pre, is_mrs, is_ref, is_rw, is_live;
   assign is_act  = (cmd == CMD_ACT);
   assign is_rd   = (cmd == CMD_RD);
   assign is_wr   = (cmd == CMD_WR);
   assign is_pre  = (cmd == CMD_PRE);
   assign is_mrs  = (cmd == CMD_MRS);
   assign is_ref  = (cmd == CMD_REF);
   assign is_rw   = is_rd || is_wr;
   assign is_live = (cmd != CMD_NOP);

   // ---------------- bank state ----------------
   logic [NBANK-1:0] open_v;
   logic [NBANK-1:0] act_vec;
   logic [NBANK-1:0] close_vec;
   logic [NBANK-1:0] ras_short;
   logic [CNT_W-1:0] act_gap [NBANK];
   logic [CNT_W-1:0] pre_gap [NBANK];

   logic             busy;
   logic             ap_start;
   logic             ap_end;
   logic [BA_W-1:0]  ap_end_bank;
   logic             sel_open;
   logic             rw_ok;

   assign sel_open = open_v[ba];
   assign rw_ok    = is_rw && sel_open && !busy;
   assign ap_start = rw_ok && a10;

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic pre_hit;
      assign pre_hit      = is_pre && (a10 || ba == BA_W'(g));
      assign act_vec[g]   = is_act && ba == BA_W'(g) && !open_v[g];
      assign close_vec[g] = pre_hit || (ap_end && ap_end_bank == BA_W'(g));
      assign ras_short[g] = pre_hit && open_v[g] && act_gap[g] < L_RAS;

      sdr_bank_slot #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .open_req(act_vec[g]), .close_req(close_vec[g]),
         .is_open(open_v[g]), .act_gap(act_gap[g]), .pre_gap(pre_gap[g])
      );
   end

   // auto-precharge burst tracking: variant picked by burst length
   if (BURST_LEN == 1) begin : g_ap_none
      assign busy        = 1'b0;
      assign ap_end      = ap_start;
      assign ap_end_bank = ba;
   end else begin : g_ap_cnt
      localparam logic [BL_W-1:0] BL_M1 = BL_W'(BURST_LEN - 1);
      logic [BL_W-1:0] ap_left;
      logic [BA_W-1:0] ap_bank;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ap_left <= '0;
            ap_bank <= '0;
         end else if (ap_start) begin
            ap_left <= BL_M1;
            ap_bank <= ba;
         end else if (ap_left != '0) begin
            ap_left <= ap_left - BL_W'(1);
         end
      end

      assign busy        = (ap_left != '0);
      assign ap_end      = (ap_left == BL_W'(1));
      assign ap_end_bank = ap_bank;
   end

   // ---------------- shared spacing timers ----------------
   logic [CNT_W-1:0] rrd_gap;
   logic [CNT_W-1:0] mrd_gap;

   sdr_gap_ctr #(.W(CNT_W), .MAX(CNT_MAX)) u_rrd (
      .clk(clk), .rst_n(rst_n), .restart(|act_vec), .gap(rrd_gap)
   );

   sdr_gap_ctr #(.W(CNT_W), .MAX(CNT_MAX)) u_mrd (
      .clk(clk), .rst_n(rst_n), .restart(is_mrs), .gap(mrd_gap)
   );

   // ---------------- rule evaluation, fixed priority ----------------
   err_e nxt_code;

   always_comb begin
      nxt_code = ERR_NONE;
      if (is_live && mrd_gap < L_MRD)                nxt_code = ERR_MRD;
      else if ((is_mrs || is_ref) && |open_v)        nxt_code = ERR_NOT_IDLE;
      else if (is_rw && busy)                        nxt_code = ERR_AP_BUSY;
      else if (is_rw && !sel_open)                   nxt_code = ERR_BANK_IDLE;
      else if (is_act && sel_open)                   nxt_code = ERR_BANK_OPEN;
      else if (is_rw && act_gap[ba] < L_RCD)         nxt_code = ERR_RCD;
      else if (|ras_short)                           nxt_code = ERR_RAS;
      else if (is_act && pre_gap[ba] < L_RP)         nxt_code = ERR_RP;
      else if (is_act && act_gap[ba] < L_RC)         nxt_code = ERR_RC;
      else if (is_act && rrd_gap < L_RRD)            nxt_code = ERR_RRD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_pulse  <= 1'b0;
         err_code   <= 4'd0;
         err_sticky <= 1'b0;
      end else begin
         err_pulse <= (nxt_code != ERR_NONE);
         if (nxt_code != ERR_NONE) begin
            err_code   <= nxt_code;
            err_sticky <= 1'b1;
         end
      end
   end

   assign bank_open = open_v;

   // ---------------- data mask tracking ----------------
   sdr_dqm_track #(.BURST_LEN(BURST_LEN), .BL_W(BL_W)) u_dqm (
      .clk(clk), .rst_n(rst_n), .dqm(dqm),
      .wr_start(rw_ok && is_wr), .rd_start(rw_ok && is_rd),
      .wr_mask(wr_mask), .rd_hiz(rd_hiz_pred)
   );

   // ---------------- assertions ----------------
   AST_PULSE_CODED: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> err_code != 4'd0); // R2
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky); // R2
   AST_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && busy) |=> err_pulse); // R5
   AST_IDLE_RW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && !sel_open) |=> err_pulse); // R6
   AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && a10) |=> bank_open == '0); // R8
   AST_IDLE_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_mrs || is_ref) && |open_v) |=> err_pulse); // R4

endmodule

// File: tb/tb_sdr_bank_checker.sv
module tb_sdr_bank_checker;

   localparam int BA_W = 2;
   localparam int NB   = 4;
   localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 10, T_RRD = 2, T_MRD = 2;
   localparam int BL   = 4;

   localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
   localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [BA_W-1:0] ba = '0;
   logic a10 = 1'b0, dqm = 1'b0;
   logic err_pulse, err_sticky, wr_mask, rd_hiz_pred;
   logic [3:0] err_code;
   logic [NB-1:0] bank_open;

   always #5 clk = ~clk;

   sdr_bank_checker #(
      .BA_W(BA_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RRD(T_RRD), .T_MRD(T_MRD), .BURST_LEN(BL)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
      .err_pulse(err_pulse), .err_code(err_code), .err_sticky(err_sticky),
      .bank_open(bank_open), .wr_mask(wr_mask), .rd_hiz_pred(rd_hiz_pred)
   );

   int vectors = 0;
   int misses  = 0;

   // ---------------- behavioural reference ----------------
   int cyc = 0;
   int m_open [NB];
   int m_act_t [NB];
   int m_pre_t [NB];
   int m_rrd_t = -1000, m_mrd_t = -1000;
   int m_ap_left = 0, m_ap_bank = 0, m_wr_left = 0;
   int m_ck_prev = 0, m_q1 = 0, m_q2 = 0;
   int m_pulse = 0, m_code = 0, m_sticky = 0;

   function automatic int any_open();
      int r = 0;
      for (int i = 0; i < NB; i++) r |= m_open[i];
      return r;
   endfunction

   function automatic int rule_code(input int valid, input logic [2:0] c, input int b, input logic a);
      if (!valid) return 0;
      if (c != C_NOP && cyc - m_mrd_t < T_MRD) return 1;
      if ((c == C_MRS || c == C_REF) && any_open() != 0) return 2;
      if (c == C_RD || c == C_WR) begin
         if (m_ap_left > 0) return 3;
         if (m_open[b] == 0) return 4;
         if (cyc - m_act_t[b] < T_RCD) return 6;
         return 0;
      end
      if (c == C_PRE) begin
         for (int i = 0; i < NB; i++)
            if ((a || i == b) && m_open[i] != 0 && cyc - m_act_t[i] < T_RAS) return 7;
         return 0;
      end
      if (c == C_ACT) begin
         if (m_open[b] != 0) return 5;
         if (cyc - m_pre_t[b] < T_RP) return 8;
         if (cyc - m_act_t[b] < T_RC) return 9;
         if (cyc - m_rrd_t < T_RRD) return 10;
      end
      return 0;
   endfunction

   task automatic check(input string tag, input string what, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         misses++;
         $display("FAIL %s cycle %0d %s actual %0d expected %0d", tag, cyc, what, got, exp);
      end
   endtask

   // one clock: drive after the falling edge, compare the combinational mask,
   // advance the model at the rising edge, compare registered outputs after it
   task automatic step(input string tag, input logic [2:0] c, input int b = 0,
                       input logic a = 1'b0, input logic d = 1'b0,
                       input logic ck = 1'b1, input logic cs = 1'b0);
      int valid, code, old_ap, old_wr, acc, snap [NB];
      cs_n = cs; {ras_n, cas_n, we_n} = c; ba = BA_W'(b); a10 = a; dqm = d; cke = ck;
      valid  = (m_ck_prev != 0 && !cs) ? 1 : 0;
      acc    = (valid != 0 && (c == C_RD || c == C_WR) && m_open[b] != 0 && m_ap_left == 0) ? 1 : 0;
      #2;
      check(tag, "wr_mask", int'(wr_mask),
            (d && ((acc != 0 && c == C_WR) || m_wr_left > 0)) ? 1 : 0);
      code = rule_code(valid, c, b, a);
      @(posedge clk);
      for (int i = 0; i < NB; i++) snap[i] = m_open[i];
      old_ap = m_ap_left;
      old_wr = m_wr_left;
      if (old_ap > 0) m_ap_left = old_ap - 1;
      if (old_wr > 0) m_wr_left = old_wr - 1;
      if (old_ap == 1 && snap[m_ap_bank] != 0) begin
         m_open[m_ap_bank] = 0; m_pre_t[m_ap_bank] = cyc;
      end
      if (valid != 0) begin
         if (c == C_MRS) m_mrd_t = cyc;
         if (c == C_ACT && snap[b] == 0) begin
            m_open[b] = 1; m_act_t[b] = cyc; m_rrd_t = cyc;
         end
         if (c == C_PRE)
            for (int i = 0; i < NB; i++)
               if ((a || i == b) && snap[i] != 0) begin m_open[i] = 0; m_pre_t[i] = cyc; end
         if (acc != 0) begin
            if (a) begin
               if (BL == 1) begin m_open[b] = 0; m_pre_t[b] = cyc; end
               else begin m_ap_left = BL - 1; m_ap_bank = b; end
            end
            m_wr_left = (c == C_WR) ? BL - 1 : 0;
         end
      end
      m_ck_prev = ck ? 1 : 0;
      m_q2 = m_q1; m_q1 = d ? 1 : 0;
      m_pulse = (code != 0) ? 1 : 0;
      if (code != 0) begin m_code = code; m_sticky = 1; end
      #1;
      check(tag, "err_pulse", int'(err_pulse), m_pulse);
      check(tag, "err_code", int'(err_code), m_code);
      check(tag, "err_sticky", int'(err_sticky), m_sticky);
      for (int i = 0; i < NB; i++) check(tag, "bank_open", int'(bank_open[i]), m_open[i]);
      check(tag, "rd_hiz_pred", int'(rd_hiz_pred), m_q2);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, C_NOP);
   endtask

   // watchdog
   initial begin
      #(200000 * 10);
      misses++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_act_t[i] = -1000; m_pre_t[i] = -1000; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R2 R13: reset state
      check("R2", "reset err_pulse", int'(err_pulse), 0);
      check("R2", "reset err_code", int'(err_code), 0);
      check("R2", "reset err_sticky", int'(err_sticky), 0);
      check("R13", "reset bank_open", int'(bank_open), 0);
      check("R12", "reset rd_hiz_pred", int'(rd_hiz_pred), 0);
      idle("R1", 2);

      // R3: command one cycle after mode set
      step("R3", C_MRS);
      step("R3", C_ACT, 0);
      idle("R3", 10);
      // R4: mode set and refresh with a bank open
      step("R4", C_MRS);
      idle("R4", 2);
      step("R4", C_REF);
      // R6: column to idle bank, activate to open bank
      step("R6", C_RD, 1);
      step("R6", C_ACT, 0);
      // R8: precharge all, then precharge an idle bank
      step("R8", C_PRE, 0, 1'b1);
      idle("R8", 1);
      step("R8", C_PRE, 2);
      idle("R8", 4);
      // R7 R11 R12: early read, then back-to-back column commands with masks
      step("R7", C_ACT, 1);
      step("R7", C_NOP);
      step("R7", C_RD, 1, 1'b0, 1'b1);
      step("R11", C_RD, 1, 1'b0, 1'b0);
      step("R11", C_WR, 1, 1'b0, 1'b1);
      step("R12", C_NOP, 0, 1'b0, 1'b0);
      step("R12", C_NOP, 0, 1'b0, 1'b1);
      step("R12", C_NOP, 0, 1'b0, 1'b1);
      step("R12", C_NOP, 0, 1'b0, 1'b1);
      step("R12", C_WR, 1, 1'b0, 1'b1);
      step("R12", C_RD, 1, 1'b0, 1'b1);
      step("R12", C_NOP, 0, 1'b0, 1'b1);
      step("R12", C_NOP, 0, 1'b0, 1'b0);
      idle("R12", 4);
      // R8 R9 R2: early precharge, then activate breaking two rules at once
      step("R8", C_ACT, 2);
      idle("R8", 2);
      step("R8", C_PRE, 2);
      step("R9", C_ACT, 2);
      idle("R9", 12);
      // R10: row-cycle only
      step("R10", C_PRE, 0, 1'b1);
      idle("R10", 4);
      step("R10", C_ACT, 3);
      idle("R10", 5);
      step("R10", C_PRE, 3);
      idle("R10", 2);
      step("R10", C_ACT, 3);
      idle("R10", 12);
      // R10: activate-to-activate across banks
      step("R10", C_PRE, 0, 1'b1);
      idle("R10", 12);
      step("R10", C_ACT, 0);
      step("R10", C_ACT, 1);
      idle("R10", 2);
      step("R10", C_ACT, 2);
      idle("R10", 4);
      // R5 R9: auto-precharge burst, busy rejection, reopen timing
      step("R5", C_RD, 0, 1'b1);
      step("R5", C_WR, 1);
      step("R5", C_NOP);
      step("R5", C_NOP);
      step("R9", C_ACT, 0);
      idle("R9", 2);
      step("R9", C_ACT, 0);
      idle("R9", 4);
      step("R5", C_WR, 0, 1'b1, 1'b1);
      step("R5", C_NOP, 0, 1'b0, 1'b1);
      step("R5", C_NOP, 0, 1'b0, 1'b0);
      step("R5", C_NOP, 0, 1'b0, 1'b1);
      step("R5", C_NOP);
      // R1: deselected mode set, and commands after a suspended clock
      step("R1", C_MRS, 0, 1'b0, 1'b0, 1'b1, 1'b1);
      step("R1", C_NOP, 0, 1'b0, 1'b0, 1'b0);
      step("R1", C_MRS, 0, 1'b0, 1'b0, 1'b1);
      step("R1", C_BST);
      step("R1", C_RD, 3);
      idle("R1", 3);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule